// File: doc/BRIEF.md
# Bus Mastership Requester

This block is the arbitration front end of a device that wants to take over a shared bus from a processor, for example a DMA engine. A one-clock start pulse from local logic makes it drive an active-low bus request. It then watches the bus grant line. Once grant is present, it watches the address strobe and the data-acknowledge line of the bus cycle in progress. It takes ownership only when grant is present and that cycle has fully ended. While it owns the bus it raises `owned`, which tells the local transfer logic it may run its own cycles. A one-clock done pulse from that logic hands the bus back.

Two handshake styles are supported, selected per request by `mode_3wire`, which is captured with the start pulse:
- **3-wire style:** ownership is claimed by asserting grant-acknowledge, and request is dropped in the same clock. The bus is released by negating grant-acknowledge.
- **2-wire style:** grant-acknowledge is never driven low. Request stays asserted for the whole time the bus is owned, and the bus is released by negating request.

All bus-side inputs pass through a synchroniser before use. After each release the block keeps its request quiet for a short idle gap before it can ask again.

Top module: `busmaster_requester`

## Requirements
- R1: During and right after synchronous reset, `br_n`=1, `bgack_n`=1 and `owned`=0.
- R2: A `start` pulse seen while idle drives `br_n` to 0 at the next clock edge, and `bgack_n` stays 1.
- R3: Grant alone never gives ownership. While `as_n`=0 or `dtack_n`=0 (after synchronisation), `owned` stays 0 and `br_n` stays 0.
- R4: With grant (`bg_n`=0) already synchronised and the block waiting, `owned` rises SYNC_STAGES+1 clock edges after the last of `as_n`/`dtack_n` goes to 1.
- R5: In 3-wire mode (`mode_3wire`=1 at start), the clock that raises `owned` also sets `bgack_n`=0 and `br_n`=1. The two outputs are never both 0.
- R6: In 2-wire mode (`mode_3wire`=0 at start), `bgack_n` stays 1 at all times, and `br_n` stays 0 for the whole time `owned`=1.
- R7: A `xfer_done` pulse while `owned`=1 sets `owned`=0, `br_n`=1 and `bgack_n`=1 at the next clock edge.
- R8: If grant goes away before the bus is free, the block goes back to requesting with `br_n`=0 and `owned`=0. When grant returns and the bus is free, it takes ownership SYNC_STAGES+2 edges after grant reappears.
- R9: After a release, `br_n` stays 1 for IDLE_GAP+1 sampled clocks even if `start` is held high. It then falls.
- R10: `start` is ignored unless the block is idle. `xfer_done` is ignored unless the bus is owned. Neither changes any output.
- R11: The handshake style is the value of `mode_3wire` at the accepted start. Changing `mode_3wire` during ownership does not change `br_n` or `bgack_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_3wire | input | 1 | 1 selects the 3-wire handshake, 0 the 2-wire one; captured at start |
| start | input | 1 | One-clock pulse asking for the bus |
| xfer_done | input | 1 | One-clock pulse handing the bus back |
| bg_n | input | 1 | Bus grant from the processor, active low, asynchronous |
| as_n | input | 1 | Address strobe of the current cycle, active low, asynchronous |
| dtack_n | input | 1 | Data acknowledge of the current cycle, active low, asynchronous |
| br_n | output | 1 | Bus request, active low, registered |
| bgack_n | output | 1 | Grant acknowledge, active low, registered |
| owned | output | 1 | High while local logic may run bus cycles |

## Verification
The assertions check the following on every cycle:
- In 3-wire mode, request is swapped for acknowledge in the same clock.
- The two active-low outputs are never low together.
- The 2-wire output pattern holds for the whole ownership.
- Every rise of `owned` follows a cycle in which both the synchronised grant and the synchronised bus-free condition were present.
- A release takes effect in the next clock.

Only the bench scenarios can show the exact latency from bus-free and from grant-return to ownership, the length of the idle gap with start held, the fall-back when grant is withdrawn, and that ignored `start`, `xfer_done` and mode changes leave the outputs alone.

// File: rtl/breq_pkg.sv
package breq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_WAITB = 3'd2,
    ST_OWN   = 3'd3,
    ST_GAP   = 3'd4
  } breq_state_e;

  localparam int unsigned BUS_IN_W = 3;
  localparam int unsigned IDX_BG   = 2;
  localparam int unsigned IDX_AS   = 1;
  localparam int unsigned IDX_DTK  = 0;
endpackage

// File: rtl/breq_sync.sv
module breq_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/breq_fsm.sv
module breq_fsm
  import breq_pkg::*;
#(
  parameter int unsigned IDLE_GAP = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        xfer_done,
  input  logic        mode_3wire,
  input  logic        bg_act,
  input  logic        bus_free,
  output logic        br_n,
  output logic        bgack_n,
  output logic        owned,
  output logic        mode_q,
  output breq_state_e state_q
);
  localparam int unsigned CW = (IDLE_GAP < 2) ? 1 : $clog2(IDLE_GAP);
  localparam logic [CW-1:0] GAP_LOAD = CW'(IDLE_GAP - 1);

  breq_state_e   state_d;
  logic [CW-1:0] gap_cnt;
  logic          mode_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_REQ;
      ST_REQ:   if (bg_act) state_d = ST_WAITB;
      ST_WAITB: begin
        if (!bg_act)       state_d = ST_REQ;
        else if (bus_free) state_d = ST_OWN;
      end
      ST_OWN:   if (xfer_done) state_d = ST_GAP;
      ST_GAP:   if (gap_cnt == '0) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign mode_d = (state_q == ST_IDLE && start) ? mode_3wire : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      gap_cnt <= '0;
      br_n    <= 1'b1;
      bgack_n <= 1'b1;
      owned   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      if (state_d == ST_GAP && state_q != ST_GAP) gap_cnt <= GAP_LOAD;
      else if (state_q == ST_GAP && gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
      br_n    <= !((state_d == ST_REQ) || (state_d == ST_WAITB) ||
                   (state_d == ST_OWN && !mode_d));
      bgack_n <= !(state_d == ST_OWN && mode_d);
      owned   <= (state_d == ST_OWN);
    end
  end
endmodule

// File: rtl/busmaster_requester.sv
module busmaster_requester
  import breq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDLE_GAP    = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_3wire,
  input  logic start,
  input  logic xfer_done,
  input  logic bg_n,
  input  logic as_n,
  input  logic dtack_n,
  output logic br_n,
  output logic bgack_n,
  output logic owned
);
  logic [BUS_IN_W-1:0] raw_in;
  logic [BUS_IN_W-1:0] sync_in;
  logic                bg_sync;
  logic                bus_free;
  logic                mode_q;
  breq_state_e         state_q;

  assign raw_in[IDX_BG]  = bg_n;
  assign raw_in[IDX_AS]  = as_n;
  assign raw_in[IDX_DTK] = dtack_n;

  breq_sync #(
    .W(BUS_IN_W), .STAGES(SYNC_STAGES), .RST_VAL('1)
  ) u_sync (
    .clk(clk), .rst(rst), .din(raw_in), .dout(sync_in)
  );

  assign bg_sync  = !sync_in[IDX_BG];
  assign bus_free = sync_in[IDX_AS] && sync_in[IDX_DTK];

  breq_fsm #(
    .IDLE_GAP(IDLE_GAP)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .xfer_done(xfer_done),
    .mode_3wire(mode_3wire), .bg_act(bg_sync), .bus_free(bus_free),
    .br_n(br_n), .bgack_n(bgack_n), .owned(owned), .mode_q(mode_q),
    .state_q(state_q)
  );
endmodule

// File: rtl/breq_checker.sv
module breq_checker (
  input logic clk,
  input logic rst,
  input logic xfer_done,
  input logic br_n,
  input logic bgack_n,
  input logic owned,
  input logic bg_s,
  input logic free_s,
  input logic mode_r
);
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (br_n && bgack_n && !owned));

  p_no_own_busy_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(owned) |-> ($past(bg_s) && $past(free_s)));

  p_swap_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(bgack_n) |-> ($rose(br_n) && owned));

  p_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(!br_n && !bgack_n));

  p_two_wire_r6: assert property (@(posedge clk) disable iff (rst)
    (owned && !mode_r) |-> (!br_n && bgack_n));

  p_three_wire_r11: assert property (@(posedge clk) disable iff (rst)
    (owned && mode_r) |-> (br_n && !bgack_n));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (owned && xfer_done) |=> (!owned && br_n && bgack_n));

  p_gap_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(owned) |=> br_n);

  p_grant_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (!owned && !bg_s) |=> !owned);
endmodule

bind busmaster_requester breq_checker u_chk (
  .clk(clk), .rst(rst), .xfer_done(xfer_done), .br_n(br_n),
  .bgack_n(bgack_n), .owned(owned), .bg_s(bg_sync), .free_s(bus_free),
  .mode_r(mode_q)
);

// File: tb/busmaster_requester_bench.sv
module busmaster_requester_bench;
  localparam int SYNC_STAGES = 2;
  localparam int IDLE_GAP    = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_3wire = 1'b0, start = 1'b0, xfer_done = 1'b0;
  logic bg_n = 1'b1, as_n = 1'b1, dtack_n = 1'b1;
  logic br_n, bgack_n, owned;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  busmaster_requester #(.SYNC_STAGES(SYNC_STAGES), .IDLE_GAP(IDLE_GAP)) u_busmaster_requester (
    .clk(clk), .rst(rst), .mode_3wire(mode_3wire), .start(start),
    .xfer_done(xfer_done), .bg_n(bg_n), .as_n(as_n), .dtack_n(dtack_n),
    .br_n(br_n), .bgack_n(bgack_n), .owned(owned)
  );

  function automatic logic exp_br_n(input logic m3, input logic own);
    return own ? m3 : 1'b0;
  endfunction
  function automatic logic exp_bgack_n(input logic m3, input logic own);
    return !(own && m3);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; start = 1'b0; xfer_done = 1'b0;
    bg_n = 1'b1; as_n = 1'b1; dtack_n = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic pulse_start(input logic m3);
    mode_3wire = m3; start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  // Request, grant with busy bus, settle, then free bus.
  task automatic acquire(input logic m3, input int busy);
    int viol = 0;
    pulse_start(m3);
    as_n = 1'b0; dtack_n = 1'b0; bg_n = 1'b0;
    tick(SYNC_STAGES + 2);
    for (int i = 0; i < busy; i++) begin
      if (owned || br_n) viol++;
      tick(1);
    end
    check(viol == 0, "R3", viol, 0);
    as_n = 1'b1;
    tick(1);
    check(!owned, "R3", owned, 0);
    dtack_n = 1'b1;
    tick(SYNC_STAGES);
    check(!owned, "R4", owned, 0);
    tick(1);
    check(owned, "R4", owned, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    tick(1);
    check(br_n && bgack_n && !owned, "R1", {br_n, bgack_n, owned}, 3'b110);
    do_reset();
    check(br_n && bgack_n && !owned, "R1", {br_n, bgack_n, owned}, 3'b110);

    // R10: done while idle ignored
    xfer_done = 1'b1; tick(1); xfer_done = 1'b0; tick(1);
    check(br_n && !owned, "R10", {br_n, owned}, 2'b10);

    // R2
    pulse_start(1'b1);
    check(!br_n && bgack_n, "R2", {br_n, bgack_n}, 2'b01);

    // 3-wire acquire + R5
    do_reset();
    acquire(1'b1, 5);
    check(br_n == 1'b1 && bgack_n == 1'b0, "R5", {br_n, bgack_n}, 2'b10);
    // R11: mode change during ownership
    mode_3wire = 1'b0; tick(3);
    check(br_n && !bgack_n, "R11", {br_n, bgack_n}, 2'b10);
    // R7
    xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
    check(!owned && br_n && bgack_n, "R7", {owned, br_n, bgack_n}, 3'b011);

    // 2-wire + R6, R10, R9
    do_reset();
    acquire(1'b0, 3);
    check(!br_n && bgack_n, "R6", {br_n, bgack_n}, 2'b01);
    pulse_start(1'b1); tick(2);
    check(owned && !br_n && bgack_n, "R10", {owned, br_n, bgack_n}, 3'b101);
    begin
      int hi = 0;
      xfer_done = 1'b1; start = 1'b1; tick(1); xfer_done = 1'b0;
      while (br_n && hi < 20) begin hi++; tick(1); end
      start = 1'b0;
      check(hi == IDLE_GAP + 1, "R9", hi, IDLE_GAP + 1);
    end

    // R8: grant withdrawn before bus free
    do_reset();
    pulse_start(1'b1);
    as_n = 1'b0; bg_n = 1'b0; tick(SYNC_STAGES + 2);
    bg_n = 1'b1; tick(SYNC_STAGES + 2);
    as_n = 1'b1; tick(6);
    check(!owned && !br_n && bgack_n, "R8", {owned, br_n, bgack_n}, 3'b001);
    bg_n = 1'b0; tick(SYNC_STAGES + 1);
    check(!owned, "R8", owned, 0);
    tick(1);
    check(owned && !bgack_n, "R8", {owned, bgack_n}, 2'b10);

    // Random rounds
    for (int r = 0; r < 40; r++) begin
      logic m3;
      int hold, mism;
      m3 = logic'($urandom_range(0, 1));
      do_reset();
      acquire(m3, int'($urandom_range(0, 8)));
      hold = int'($urandom_range(1, 10));
      mism = 0;
      for (int k = 0; k < hold; k++) begin
        mode_3wire = logic'($urandom_range(0, 1));
        if (br_n !== exp_br_n(m3, 1'b1) || bgack_n !== exp_bgack_n(m3, 1'b1)) mism++;
        tick(1);
      end
      check(mism == 0, m3 ? "R5" : "R6", mism, 0);
      xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
      check(!owned && br_n == exp_br_n(m3, 1'b0) | 1'b1 && bgack_n == exp_bgack_n(m3, 1'b0),
            "R7", {owned, br_n, bgack_n}, 3'b011);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule